// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block steers the program counter of a small shader core. Each cycle it either issues the word at the current address or spends the cycle closing a scope. Arithmetic words only step the counter. Flow-control words do the branching: jumps, calls, if/else pairs and counted loops. Every call, if/else and loop pushes a scope record onto an internal stack. A record holds an end address, a resume address, a restart address, a repeat count and a counter step. There is no return instruction. Before each issue the sequencer compares the counter with the end address of the top record, and that comparison is what closes the scope.

Program words come from an external program store. That store is addressed by `pc_o` and answers on `instr_i` in the same cycle. Two condition flags are written by the arithmetic datapath through a flag port. Boolean and integer uniforms arrive as static configuration buses. A run begins with a start pulse carrying the entry address. It ends with `done_o` on an end word, or with `ovf_o` if a push finds the stack full. The 8-bit loop counter is exported for indexed addressing.

Top module: `fc_sequencer`

## Requirements
- R1: After reset `pc_o`=0 and `issue_o`, `done_o`, `ovf_o` and `loop_ctr_o` are all 0. A `start_i` pulse loads `pc_o` from `entry_i`. The same pulse empties the stack and clears the flags, the loop counter, `done_o` and `ovf_o`.
- R2: Word layout: opcode [31:26], reference x [25], reference y [24], combine mode [23:22], target [21:12], count [11:4], uniform index [3:0]. Opcodes are 0 no-op, 1 end, 2 flag jump, 3 uniform jump, 4 call, 5 flag call, 6 uniform call, 7 flag if, 8 uniform if, 9 loop. Any other opcode is an arithmetic step. A no-op or an arithmetic step issues for one cycle and advances the counter by 1. All address arithmetic wraps modulo 1024.
- R3: In a cycle where the stack is non-empty and `pc_o` equals the top end address, nothing is issued and the top step is added to the loop counter. If the top repeat count is 0, the counter goes to the resume address and the record is popped. Otherwise the count decrements and the counter goes to the restart address. The test repeats on the next cycle.
- R4: A taken call pushes {end = target+count, resume = pc+1, repeat 0, step 0} and jumps to the target. Opcode 4 is always taken. Opcode 5 is taken when the flag condition holds. Opcode 6 is taken when the selected boolean uniform is 1. A call that is not taken advances by 1.
- R5: An if with a true condition pushes {end = target, resume = target+count} and continues at pc+1. With a false condition it pushes {end = target+count, resume = target+count} and continues at the target. Opcode 7 tests the flag condition and opcode 8 tests the boolean uniform.
- R6: A loop loads the loop counter with byte [15:8] of the selected integer uniform. It pushes {end = target+1, resume = target+1, restart = pc+1}, takes the repeat count from byte [7:0] and the step from byte [23:16], then continues at pc+1. Integer uniform k occupies `int_unif_i[24k+23:24k]`.
- R7: The flag condition sets a = (ref x == flag 0) and b = (ref y == flag 1). Mode 0 gives a|b, mode 1 gives a&b, mode 2 gives a and mode 3 gives b.
- R8: Opcode 2 jumps to the target when the flag condition holds. Opcode 3 jumps when boolean uniform `bool_unif_i[index]` is 1. Either one advances by 1 when not taken.
- R9: An issued end word raises `done_o` on the next cycle. After that nothing issues and the counter holds until the next start.
- R10: The stack holds 8 records. An issued push word that finds the stack full sets a sticky `ovf_o`, stops execution and leaves `pc_o` unchanged.
- R11: While running, `flag_we_i` loads `flag_i` into the flags at the clock edge. Words issued from the next cycle onward see the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run at `entry_i` |
| entry_i | input | 10 | Entry address |
| instr_i | input | 32 | Program word at `pc_o` |
| flag_we_i | input | 1 | Condition flag write strobe |
| flag_i | input | 2 | Condition flag values (bit 0 = flag 0) |
| bool_unif_i | input | 16 | Boolean uniforms |
| int_unif_i | input | 96 | Four integer uniforms, 24 bits each |
| pc_o | output | 10 | Current program counter |
| issue_o | output | 1 | Word at `pc_o` is issued this cycle |
| done_o | output | 1 | Run finished on an end word |
| ovf_o | output | 1 | Sticky stack overflow |
| loop_ctr_o | output | 8 | Loop counter |

## Verification
The bench builds the block with its defaults: an 8-record stack, 16 boolean uniforms and 4 integer uniforms. With that depth, a call that targets itself overflows on its ninth issue, which keeps the overflow path short. Each cycle is checked against a queue-based model. The programs are chosen to reach these cases:
- two scopes that end on the same address, giving back-to-back redirect cycles;
- loops whose repeat count gives several passes;
- both arms of each if;
- every jump and call variant, taken and not taken.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int ADDR_W  = 10;
  localparam int CNT_W   = 8;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam logic [OP_W-1:0] OP_NOP     = 6'd0;
  localparam logic [OP_W-1:0] OP_END     = 6'd1;
  localparam logic [OP_W-1:0] OP_JMP_CC  = 6'd2;
  localparam logic [OP_W-1:0] OP_JMP_UB  = 6'd3;
  localparam logic [OP_W-1:0] OP_CALL    = 6'd4;
  localparam logic [OP_W-1:0] OP_CALL_CC = 6'd5;
  localparam logic [OP_W-1:0] OP_CALL_UB = 6'd6;
  localparam logic [OP_W-1:0] OP_IF_CC   = 6'd7;
  localparam logic [OP_W-1:0] OP_IF_UB   = 6'd8;
  localparam logic [OP_W-1:0] OP_LOOP    = 6'd9;

  typedef enum logic [1:0] {CM_OR = 2'd0, CM_AND = 2'd1, CM_X = 2'd2, CM_Y = 2'd3} cmode_e;

  typedef struct packed {
    addr_t end_a;
    addr_t ret_a;
    addr_t rst_a;
    cnt_t  rep;
    cnt_t  step;
  } scope_t;
endpackage

// File: rtl/fc_cond_eval.sv
module fc_cond_eval import fc_pkg::*; (
  input  logic [1:0] flags_i,
  input  logic       ref_x_i,
  input  logic       ref_y_i,
  input  logic [1:0] mode_i,
  output logic       hit_o
);
  logic mx, my;
  assign mx = (ref_x_i == flags_i[0]);
  assign my = (ref_y_i == flags_i[1]);

  always_comb begin
    unique case (cmode_e'(mode_i))
      CM_OR:   hit_o = mx | my;
      CM_AND:  hit_o = mx & my;
      CM_X:    hit_o = mx;
      default: hit_o = my;
    endcase
  end
endmodule

// File: rtl/fc_scope_stack.sv
module fc_scope_stack import fc_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   push_i,
  input  logic   pop_i,
  input  logic   dec_i,
  input  scope_t data_i,
  output scope_t top_o,
  output logic   empty_o,
  output logic   full_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  scope_t             mem_q [DEPTH];
  logic [PTR_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   top_idx, wr_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PTR_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (push_i)        cnt_q <= cnt_q + 1'b1;
    else if (pop_i)         cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o)       mem_q[wr_idx] <= data_i;
    else if (dec_i && !empty_o)  mem_q[top_idx].rep <= mem_q[top_idx].rep - 1'b1;
  end

  assert_no_push_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || dec_i) |-> !empty_o);
  assert_push_grows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |=> !empty_o);
endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer import fc_pkg::*; #(
  parameter int STACK_DEPTH = 8,
  parameter int NUM_BOOL    = 16,
  parameter int NUM_INT     = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         entry_i,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic                      flag_we_i,
  input  logic [1:0]                flag_i,
  input  logic [NUM_BOOL-1:0]       bool_unif_i,
  input  logic [NUM_INT*3*CNT_W-1:0] int_unif_i,
  output logic [ADDR_W-1:0]         pc_o,
  output logic                      issue_o,
  output logic                      done_o,
  output logic                      ovf_o,
  output logic [CNT_W-1:0]          loop_ctr_o
);
  localparam int BOOL_W = $clog2(NUM_BOOL);
  localparam int INT_W  = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;
  localparam int IU_W   = 3 * CNT_W;

  addr_t      pc_q, pc_n, pc_inc;
  cnt_t       lc_q, lc_n;
  logic [1:0] flags_q;
  logic       run_q, done_q, ovf_q;

  scope_t     top, push_d;
  logic       stk_empty, stk_full;
  logic       push_req, push, pop, dec, fin, ovf_set, scope_hit;

  logic [OP_W-1:0] f_op;
  logic            f_rx, f_ry;
  logic [1:0]      f_md;
  addr_t           f_tgt, f_cnt;
  logic [3:0]      f_uid;
  logic            cond_hit, bool_hit, take;
  logic [IU_W-1:0] iu;

  assign f_op  = instr_i[31:26];
  assign f_rx  = instr_i[25];
  assign f_ry  = instr_i[24];
  assign f_md  = instr_i[23:22];
  assign f_tgt = instr_i[21:12];
  assign f_cnt = addr_t'(instr_i[11:4]);
  assign f_uid = instr_i[3:0];

  assign bool_hit = bool_unif_i[f_uid[BOOL_W-1:0]];
  assign iu       = int_unif_i[f_uid[INT_W-1:0]*IU_W +: IU_W];
  assign pc_inc   = pc_q + 1'b1;

  fc_cond_eval u_cond (
    .flags_i (flags_q),
    .ref_x_i (f_rx),
    .ref_y_i (f_ry),
    .mode_i  (f_md),
    .hit_o   (cond_hit)
  );

  assign scope_hit = run_q && !stk_empty && (pc_q == top.end_a);
  assign issue_o   = run_q && !scope_hit;

  always_comb begin
    pc_n     = pc_q;
    lc_n     = lc_q;
    push_req = 1'b0;
    push_d   = '0;
    pop      = 1'b0;
    dec      = 1'b0;
    fin      = 1'b0;
    take     = 1'b0;
    if (scope_hit) begin
      lc_n = lc_q + top.step;
      if (top.rep == '0) begin
        pc_n = top.ret_a;
        pop  = 1'b1;
      end else begin
        pc_n = top.rst_a;
        dec  = 1'b1;
      end
    end else if (issue_o) begin
      pc_n = pc_inc;
      case (f_op)
        OP_END: begin
          fin  = 1'b1;
          pc_n = pc_q;
        end
        OP_JMP_CC: if (cond_hit) pc_n = f_tgt;
        OP_JMP_UB: if (bool_hit) pc_n = f_tgt;
        OP_CALL, OP_CALL_CC, OP_CALL_UB: begin
          take = (f_op == OP_CALL) || (f_op == OP_CALL_CC && cond_hit) ||
                 (f_op == OP_CALL_UB && bool_hit);
          if (take) begin
            push_req = 1'b1;
            push_d   = '{end_a: f_tgt + f_cnt, ret_a: pc_inc, rst_a: f_tgt, rep: '0, step: '0};
            pc_n     = f_tgt;
          end
        end
        OP_IF_CC, OP_IF_UB: begin
          take     = (f_op == OP_IF_CC) ? cond_hit : bool_hit;
          push_req = 1'b1;
          if (take) begin
            push_d = '{end_a: f_tgt, ret_a: f_tgt + f_cnt, rst_a: pc_inc, rep: '0, step: '0};
          end else begin
            push_d = '{end_a: f_tgt + f_cnt, ret_a: f_tgt + f_cnt, rst_a: f_tgt, rep: '0, step: '0};
            pc_n   = f_tgt;
          end
        end
        OP_LOOP: begin
          push_req = 1'b1;
          push_d   = '{end_a: f_tgt + 1'b1, ret_a: f_tgt + 1'b1, rst_a: pc_inc,
                       rep: iu[CNT_W-1:0], step: iu[3*CNT_W-1:2*CNT_W]};
          lc_n     = iu[2*CNT_W-1:CNT_W];
        end
        default: ;
      endcase
      if (push_req && stk_full) begin
        pc_n = pc_q;
        lc_n = lc_q;
      end
    end
  end

  assign ovf_set = push_req && stk_full;
  assign push    = push_req && !stk_full && !start_i;

  fc_scope_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .push_i  (push),
    .pop_i   (pop && !start_i),
    .dec_i   (dec && !start_i),
    .data_i  (push_d),
    .top_o   (top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      lc_q    <= '0;
      flags_q <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (start_i) begin
      pc_q    <= entry_i;
      lc_q    <= '0;
      flags_q <= '0;
      run_q   <= 1'b1;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (run_q) begin
      pc_q <= pc_n;
      lc_q <= lc_n;
      if (flag_we_i) flags_q <= flag_i;
      if (fin) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
      if (ovf_set) begin
        run_q <= 1'b0;
        ovf_q <= 1'b1;
      end
    end
  end

  assign pc_o       = pc_q;
  assign done_o     = done_q;
  assign ovf_o      = ovf_q;
  assign loop_ctr_o = lc_q;

  assert_end_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && f_op == OP_END && !start_i) |=> (done_o && !issue_o));
  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(pc_o) && !issue_o));
  assert_call_jump_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && f_op == OP_CALL && !stk_full && !start_i) |=> (pc_o == $past(f_tgt)));
  assert_loop_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && f_op == OP_LOOP && !stk_full && !start_i) |=>
      (loop_ctr_o == $past(iu[2*CNT_W-1:CNT_W])));
  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && f_op > OP_LOOP && !start_i) |=> (pc_o == $past(pc_o) + 1'b1));
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !start_i) |=> (ovf_o && !issue_o));
  assert_start_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pc_o == $past(entry_i) && !done_o && !ovf_o && loop_ctr_o == '0));
endmodule

// File: tb/fc_sequencer_bench.sv
module fc_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  entry_i = '0;
  logic [31:0] instr_i;
  logic        flag_we_i = 1'b0;
  logic [1:0]  flag_i = '0;
  logic [15:0] bool_unif = '0;
  logic [95:0] int_unif = '0;
  logic [9:0]  pc_o;
  logic        issue_o, done_o, ovf_o;
  logic [7:0]  loop_ctr_o;

  logic [31:0] mem [1024];
  assign instr_i = mem[pc_o];

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_sequencer u_fc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .entry_i(entry_i),
    .instr_i(instr_i), .flag_we_i(flag_we_i), .flag_i(flag_i),
    .bool_unif_i(bool_unif), .int_unif_i(int_unif),
    .pc_o(pc_o), .issue_o(issue_o), .done_o(done_o), .ovf_o(ovf_o),
    .loop_ctr_o(loop_ctr_o)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input bit rx, input bit ry,
                                      input int md, input int tg, input int ct, input int u);
    return {op[5:0], rx, ry, md[1:0], tg[9:0], ct[7:0], u[3:0]};
  endfunction

  // behavioural reference model
  typedef struct {int e; int r; int s; int rep; int stp;} sc_t;
  sc_t stk[$];
  int  m_pc, m_lc;
  bit  m_run, m_done, m_ovf;
  bit [1:0] m_f;

  function automatic bit m_hit();
    return m_run && stk.size() > 0 && m_pc == stk[$].e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk.delete(); m_pc = 0; m_lc = 0; m_run = 0; m_done = 0; m_ovf = 0; m_f = 0;
    end else if (start_i) begin
      stk.delete(); m_pc = int'(entry_i); m_lc = 0; m_run = 1; m_done = 0; m_ovf = 0; m_f = 0;
    end else if (m_run) begin
      if (m_hit()) begin
        m_lc = (m_lc + stk[$].stp) % 256;
        if (stk[$].rep == 0) begin m_pc = stk[$].r; void'(stk.pop_back()); end
        else begin stk[$].rep--; m_pc = stk[$].s; end
      end else begin
        automatic logic [31:0] w = mem[m_pc];
        automatic int op = int'(w[31:26]);
        automatic int tg = int'(w[21:12]);
        automatic int ct = int'(w[11:4]);
        automatic int u  = int'(w[3:0]);
        automatic bit a = (w[25] == m_f[0]);
        automatic bit b = (w[24] == m_f[1]);
        automatic bit c = (w[23:22] == 0) ? (a || b) : (w[23:22] == 1) ? (a && b) :
                          (w[23:22] == 2) ? a : b;
        automatic bit bl = bool_unif[u];
        automatic logic [23:0] iu = int_unif[(u % 4) * 24 +: 24];
        automatic bit do_push = 0;
        automatic sc_t ns = '{0, 0, 0, 0, 0};
        automatic int npc = (m_pc + 1) % 1024;
        automatic int nlc = m_lc;
        if (op == 1) begin m_run = 0; m_done = 1; npc = m_pc; end
        else if (op == 2 && c) npc = tg;
        else if (op == 3 && bl) npc = tg;
        else if ((op == 4) || (op == 5 && c) || (op == 6 && bl)) begin
          do_push = 1; ns = '{(tg + ct) % 1024, (m_pc + 1) % 1024, tg, 0, 0}; npc = tg;
        end else if (op == 7 || op == 8) begin
          do_push = 1;
          if ((op == 7) ? c : bl) ns = '{tg, (tg + ct) % 1024, (m_pc + 1) % 1024, 0, 0};
          else begin ns = '{(tg + ct) % 1024, (tg + ct) % 1024, tg, 0, 0}; npc = tg; end
        end else if (op == 9) begin
          do_push = 1; ns = '{(tg + 1) % 1024, (tg + 1) % 1024, (m_pc + 1) % 1024,
                              int'(iu[7:0]), int'(iu[23:16])};
          nlc = int'(iu[15:8]);
        end
        if (do_push && stk.size() == DEPTH) begin
          m_ovf = 1; m_run = 0;
        end else begin
          if (do_push) stk.push_back(ns);
          m_pc = npc; m_lc = nlc;
        end
      end
      if (flag_we_i) m_f = flag_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 pc", int'(pc_o), m_pc);
      chk("R3 issue", int'(issue_o), int'(m_run && !m_hit()));
      chk("R9 done", int'(done_o), int'(m_done));
      chk("R10 ovf", int'(ovf_o), int'(m_ovf));
      chk("R6 loop_ctr", int'(loop_ctr_o), m_lc);
    end
  end

  int n_iss, n_cyc;
  bit seen [1024];

  task automatic run_prog(input int entry, input bit fwe, input logic [1:0] fval);
    @(negedge clk); start_i = 1; entry_i = 10'(entry);
    @(negedge clk); start_i = 0; flag_we_i = fwe; flag_i = fval;
    n_iss = 0; n_cyc = 0;
    foreach (seen[i]) seen[i] = 0;
    while (!(done_o || ovf_o) && n_cyc < 2000) begin
      if (issue_o) begin n_iss++; seen[pc_o] = 1; end
      n_cyc++;
      @(negedge clk);
      flag_we_i = 0;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = enc(63, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pc", int'(pc_o), 0);
    chk("R1 reset issue", int'(issue_o), 0);
    chk("R1 reset done", int'(done_o), 0);

    // R4 plain call, R2 sequential steps
    mem[16] = enc(0, 0, 0, 0, 0, 0, 0);
    mem[17] = enc(4, 0, 0, 0, 40, 2, 0);
    mem[19] = enc(1, 0, 0, 0, 0, 0, 0);
    run_prog(16, 0, 0);
    chk("R4 call issues", n_iss, 6);
    chk("R3 call cycles", n_cyc, 7);
    chk("R9 call done", int'(done_o), 1);
    chk("R2 call visited 41", int'(seen[41]), 1);

    // R6 counted loop
    clear_mem();
    int_unif[24 +: 24] = {8'd3, 8'd5, 8'd2};
    mem[0] = enc(9, 0, 0, 0, 3, 0, 1);
    mem[4] = enc(1, 0, 0, 0, 0, 0, 0);
    run_prog(0, 0, 0);
    chk("R6 loop issues", n_iss, 11);
    chk("R6 loop cycles", n_cyc, 14);
    chk("R6 loop counter", int'(loop_ctr_o), 14);

    // R3 nested scopes sharing one end address, R5 uniform if both arms
    clear_mem();
    int_unif[0 +: 24] = {8'd1, 8'd0, 8'd1};
    mem[0] = enc(9, 0, 0, 0, 5, 0, 0);
    mem[1] = enc(8, 0, 0, 0, 5, 1, 0);
    mem[6] = enc(1, 0, 0, 0, 0, 0, 0);
    bool_unif[0] = 1;
    run_prog(0, 0, 0);
    chk("R3 nested issues", n_iss, 10);
    chk("R3 nested cycles", n_cyc, 14);
    chk("R3 nested counter", int'(loop_ctr_o), 2);
    chk("R5 then arm skips else", int'(seen[5]), 0);
    bool_unif[0] = 0;
    run_prog(0, 0, 0);
    chk("R5 else arm issues", n_iss, 6);
    chk("R5 else arm cycles", n_cyc, 10);
    chk("R5 else skips then", int'(seen[2]), 0);

    // R11 flag write, R7 AND mode, R5 flag if
    clear_mem();
    mem[101] = enc(7, 1, 0, 1, 104, 2, 0);
    mem[106] = enc(1, 0, 0, 0, 0, 0, 0);
    run_prog(100, 1, 2'b01);
    chk("R11 true path body", int'(seen[102]), 1);
    chk("R7 and-mode true skips else", int'(seen[104]), 0);
    chk("R5 true issues", n_iss, 5);
    run_prog(100, 1, 2'b11);
    chk("R7 and-mode false runs else", int'(seen[104]), 1);
    chk("R11 false path skips then", int'(seen[102]), 0);

    // R8 jumps, R4 gated calls, R7 x/y/or modes
    clear_mem();
    mem[200] = enc(2, 0, 0, 2, 210, 0, 0);
    mem[210] = enc(3, 0, 0, 0, 220, 0, 3);
    mem[211] = enc(6, 0, 0, 0, 300, 1, 3);
    mem[212] = enc(5, 0, 1, 3, 300, 1, 0);
    mem[213] = enc(2, 1, 1, 0, 300, 0, 0);
    mem[214] = enc(1, 0, 0, 0, 0, 0, 0);
    mem[220] = enc(5, 0, 1, 0, 230, 1, 0);
    mem[221] = enc(1, 0, 0, 0, 0, 0, 0);
    bool_unif[3] = 0;
    run_prog(200, 0, 0);
    chk("R8 untaken issues", n_iss, 6);
    chk("R8 x-mode jump taken", int'(seen[201]), 0);
    chk("R4 untaken calls", int'(seen[300]), 0);
    bool_unif[3] = 1;
    run_prog(200, 0, 0);
    chk("R8 uniform jump taken", int'(seen[220]), 1);
    chk("R4 or-mode call issues", n_iss, 5);
    chk("R4 or-mode call cycles", n_cyc, 6);

    // R10 overflow on ninth nested push
    clear_mem();
    mem[0] = enc(4, 0, 0, 0, 0, 5, 0);
    run_prog(0, 0, 0);
    chk("R10 overflow flag", int'(ovf_o), 1);
    chk("R10 overflow issues", n_iss, DEPTH + 1);
    chk("R10 no done", int'(done_o), 0);
    @(negedge clk);
    chk("R10 pc held", int'(pc_o), 0);

    // R1 restart clears overflow
    mem[0] = enc(1, 0, 0, 0, 0, 0, 0);
    run_prog(0, 0, 0);
    chk("R1 restart clears ovf", int'(ovf_o), 0);
    chk("R1 restart done", int'(done_o), 1);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule